// File: doc/BRIEF.md
# Three-Phase Aligned Memory Copy Engine

This block copies a run of bytes from a source byte address to a destination byte address over a single word-wide memory port. The work is split into three phases. The head phase writes partial destination words until the destination reaches the alignment granularity `AB`, which may be wider than the `WB`-byte datapath word. The body phase writes whole aligned destination words, one per cycle. The tail phase writes the remaining partial word under byte enables. When the source and destination offsets differ, a one-word carry register and a byte shifter join two neighbouring source words into each destination word.

All progress is visible on output ports: source address, destination address, remaining length and current phase. A copy can be stopped between beats with `abort_i`. It is resumed by issuing a new command with the values read from those ports, with the phase included. `stall_i` freezes the engine for as long as it is high. The memory read is combinational: `mem_rd_data` follows `mem_rd_addr` in the same cycle. The states are `ST_IDLE`, `ST_HEAD`, `ST_BODY`, `ST_TAIL` and `ST_DONE`.

The state transitions are:
- `ST_IDLE`→`ST_DONE` on a zero-length command.
- `ST_IDLE`→head, body or tail on any other command, according to `cmd_phase`.
- `ST_HEAD`→`ST_BODY` once the destination is aligned or no bytes are left.
- `ST_BODY`→`ST_TAIL` once fewer than `WB` bytes are left.
- `ST_TAIL`→`ST_DONE` once no bytes are left.
- Any phase→`ST_IDLE` on abort.
- `ST_DONE`→`ST_IDLE` always.

Top module: `memcpy3_engine`

## Requirements
- R1: A command with length zero makes `done_o` high in the cycle after the command edge, and the engine raises neither `mem_rd_en` nor `mem_wr_en` for that command.
- R2: Head-phase writes (phase code 0) happen only while the destination address has a nonzero remainder modulo `AB`. The head phase covers exactly the bytes up to the next `AB` boundary (or the whole length, if that is shorter), with one write per destination word touched.
- R3: Every body-phase write (phase code 1) has all byte enables set and a word-aligned destination. Within one body phase at most two cycles carry no write: an optional source-priming cycle and the exit cycle.
- R4: The tail phase (phase code 2) issues at most one write. That write has byte enables set only on the low `prog_len` bytes, and it occurs only when 0 < `prog_len` < `WB`. After it, `prog_len` is zero.
- R5: A nonzero copy started at phase 0 visits phases 0, 1 and 2 in that order, each for at least one cycle, with no phase code ever decreasing. `ST_DONE` is entered only from the tail phase or from idle.
- R6: After completion, every destination byte equals the source byte at the same distance from the start, for any source and destination offsets. No byte outside the destination range changes.
- R7: In an uninterrupted copy, each destination word in the range is written exactly once, and no other word is written.
- R8: Each write advances `prog_src` and `prog_dst` by the number of bytes written and lowers `prog_len` by the same amount. At completion, `prog_len` is zero and both addresses have moved by the original length.
- R9: When `abort_i` is high in a phase state, the engine goes idle without a memory access or `done_o` in that cycle. Memory then holds exactly the first (original length − `prog_len`) copied bytes, and both addresses have advanced by that count.
- R10: A command built from `prog_src`, `prog_dst`, `prog_len` and `prog_phase` after an abort completes the copy with a correct result.
- R11: While `stall_i` is high in a phase state, there are no memory accesses and the progress registers hold. The final result is unaffected by the stalls.
- R12: `done_o` is high for exactly one cycle, after which the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Command strobe, accepted in idle |
| cmd_src | input | AW | Source byte address |
| cmd_dst | input | AW | Destination byte address |
| cmd_len | input | LW | Byte count |
| cmd_phase | input | 2 | Starting phase: 0 head, 1 body, 2 or 3 tail |
| abort_i | input | 1 | Stop between beats |
| stall_i | input | 1 | Freeze the engine this cycle |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_addr | output | AW-log2(WB) | Source word address |
| mem_rd_data | input | 8*WB | Read data, same cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | AW-log2(WB) | Destination word address |
| mem_wr_data | output | 8*WB | Write data |
| mem_wr_be | output | WB | Byte enables |
| prog_src | output | AW | Next source byte address |
| prog_dst | output | AW | Next destination byte address |
| prog_len | output | LW | Bytes still to copy |
| prog_phase | output | 2 | Current or last phase code |
| busy_o | output | 1 | Not idle |
| done_o | output | 1 | Completion pulse |

## Verification
The sweep covers every source and destination offset within the alignment granule and every length from zero up to several words. This reaches the following corner cases:
- Copies whose head ends in the middle of a word; a wrong head-end rule would spill bytes or miss the alignment boundary.
- Copies whose body is empty; a design that skips a phase or loops in one would break the phase order or hang.
- Copies whose tail is empty; a design that ends on the wrong length would write a stray tail word.

A wrong shift amount or a stale carry word shows up as corrupted destination bytes whenever the source and destination offsets differ. Re-priming the carry on every beat shows up as extra idle body cycles.

Aborts are injected at every cycle position of one misaligned copy, and the copy is then resumed. An engine that commits its registers ahead of its writes leaves memory and `prog_len` in disagreement. Stall patterns check that a frozen cycle neither accesses memory nor advances progress.

// File: rtl/memcpy3_pkg.sv
package memcpy3_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL,
        ST_DONE
    } eng_state_t;

    localparam logic [1:0] PH_HEAD = 2'd0;
    localparam logic [1:0] PH_BODY = 2'd1;
    localparam logic [1:0] PH_TAIL = 2'd2;

    function automatic eng_state_t phase_to_state(input logic [1:0] ph);
        unique case (ph)
            PH_HEAD: return ST_HEAD;
            PH_BODY: return ST_BODY;
            default: return ST_TAIL;
        endcase
    endfunction

endpackage

// File: rtl/memcpy3_merge.sv
module memcpy3_merge #(
    parameter int WB = 8
) (
    input  logic [8*WB-1:0]         lo_word,
    input  logic [8*WB-1:0]         hi_word,
    input  logic [$clog2(WB)-1:0]   shift,
    output logic [8*WB-1:0]         out_word
);
    localparam int LB = $clog2(WB);
    localparam int PW = LB + 4;

    logic [16*WB-1:0] pair;
    assign pair = {hi_word, lo_word};

    for (genvar i = 0; i < WB; i++) begin : g_byte
        logic [PW-1:0] pos;
        assign pos = PW'(i * 8) + PW'({shift, 3'b000});
        assign out_word[8*i +: 8] = pair[pos +: 8];
    end

endmodule

// File: rtl/memcpy3_bemask.sv
module memcpy3_bemask #(
    parameter int WB = 8
) (
    input  logic [$clog2(WB)-1:0] first,
    input  logic [$clog2(WB):0]   count,
    output logic [WB-1:0]         be
);
    localparam int LB = $clog2(WB);

    logic [LB:0] lim;
    assign lim = {1'b0, first} + count;

    for (genvar i = 0; i < WB; i++) begin : g_lane
        assign be[i] = ((LB+1)'(i) >= {1'b0, first}) && ((LB+1)'(i) < lim);
    end

endmodule

// File: rtl/memcpy3_engine.sv
module memcpy3_engine
    import memcpy3_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int WB = 8,
    parameter int AB = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_start,
    input  logic [AW-1:0]               cmd_src,
    input  logic [AW-1:0]               cmd_dst,
    input  logic [LW-1:0]               cmd_len,
    input  logic [1:0]                  cmd_phase,
    input  logic                        abort_i,
    input  logic                        stall_i,
    output logic                        mem_rd_en,
    output logic [AW-$clog2(WB)-1:0]    mem_rd_addr,
    input  logic [8*WB-1:0]             mem_rd_data,
    output logic                        mem_wr_en,
    output logic [AW-$clog2(WB)-1:0]    mem_wr_addr,
    output logic [8*WB-1:0]             mem_wr_data,
    output logic [WB-1:0]               mem_wr_be,
    output logic [AW-1:0]               prog_src,
    output logic [AW-1:0]               prog_dst,
    output logic [LW-1:0]               prog_len,
    output logic [1:0]                  prog_phase,
    output logic                        busy_o,
    output logic                        done_o
);
    localparam int LB  = $clog2(WB);
    localparam int AL  = $clog2(AB);
    localparam int DW  = 8 * WB;
    localparam int WAW = AW - LB;

    eng_state_t state_q, state_d;

    logic [AW-1:0]  src_q, dst_q;
    logic [LW-1:0]  len_q;
    logic [1:0]     phase_q;
    logic [DW-1:0]  carry_d_q;
    logic [WAW-1:0] carry_a_q;
    logic           carry_v_q;

    // ---------------- beat arithmetic ----------------
    logic [LB-1:0]  dst_off;
    logic [LB:0]    room, nbytes;
    logic [AW-1:0]  base;
    logic [LB-1:0]  shift;
    logic [WAW-1:0] lo_wa;
    logic           head_work, body_work, tail_work, work;
    logic           in_phase, go, beat, direct, carry_hit, issue_wr;
    logic [DW-1:0]  merged, merge_lo;
    logic [WB-1:0]  lane_be;

    assign dst_off   = dst_q[LB-1:0];
    assign room      = (LB+1)'(WB) - {1'b0, dst_off};
    assign nbytes    = (len_q < LW'(room)) ? len_q[LB:0] : room;
    assign base      = src_q - AW'(dst_off);
    assign shift     = base[LB-1:0];
    assign lo_wa     = base[AW-1:LB];

    assign head_work = (|dst_q[AL-1:0]) && (len_q != '0);
    assign body_work = len_q >= LW'(WB);
    assign tail_work = len_q != '0;

    assign in_phase  = (state_q == ST_HEAD) || (state_q == ST_BODY) || (state_q == ST_TAIL);
    assign go        = in_phase && !abort_i && !stall_i;

    always_comb begin
        unique case (state_q)
            ST_HEAD: work = head_work;
            ST_BODY: work = body_work;
            ST_TAIL: work = tail_work;
            default: work = 1'b0;
        endcase
    end

    assign beat      = go && work;
    assign direct    = (shift == '0);
    assign carry_hit = carry_v_q && (carry_a_q == lo_wa);
    assign issue_wr  = beat && (direct || carry_hit);
    assign merge_lo  = direct ? mem_rd_data : carry_d_q;

    memcpy3_merge #(.WB(WB)) u_merge (
        .lo_word  (merge_lo),
        .hi_word  (mem_rd_data),
        .shift    (shift),
        .out_word (merged)
    );

    memcpy3_bemask #(.WB(WB)) u_bemask (
        .first (dst_off),
        .count (nbytes),
        .be    (lane_be)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_start)
                         state_d = (cmd_len == '0) ? ST_DONE : phase_to_state(cmd_phase);
            ST_HEAD: if (abort_i)                    state_d = ST_IDLE;
                     else if (!stall_i && !head_work) state_d = ST_BODY;
            ST_BODY: if (abort_i)                    state_d = ST_IDLE;
                     else if (!stall_i && !body_work) state_d = ST_TAIL;
            ST_TAIL: if (abort_i)                    state_d = ST_IDLE;
                     else if (!stall_i && !tail_work) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- architected progress ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
        end else if (state_q == ST_IDLE && cmd_start) begin
            src_q <= cmd_src;
            dst_q <= cmd_dst;
            len_q <= cmd_len;
        end else if (issue_wr) begin
            src_q <= src_q + AW'(nbytes);
            dst_q <= dst_q + AW'(nbytes);
            len_q <= len_q - LW'(nbytes);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_HEAD;
        else if (state_q == ST_IDLE && cmd_start)
            phase_q <= cmd_phase;
        else if (state_q == ST_HEAD && state_d == ST_BODY)
            phase_q <= PH_BODY;
        else if (state_q == ST_BODY && state_d == ST_TAIL)
            phase_q <= PH_TAIL;
    end

    // ---------------- carry word (not architected) ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_v_q <= 1'b0;
            carry_a_q <= '0;
            carry_d_q <= '0;
        end else if (state_q == ST_IDLE || abort_i) begin
            carry_v_q <= 1'b0;
        end else if (beat && !direct) begin
            carry_v_q <= 1'b1;
            carry_a_q <= mem_rd_addr;
            carry_d_q <= mem_rd_data;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_rd_en   = beat;
        mem_rd_addr = (direct || !carry_hit) ? lo_wa : lo_wa + WAW'(1);
        mem_wr_en   = issue_wr;
        mem_wr_addr = dst_q[AW-1:LB];
        mem_wr_data = merged;
        mem_wr_be   = lane_be;
        prog_src    = src_q;
        prog_dst    = dst_q;
        prog_len    = len_q;
        prog_phase  = phase_q;
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
    end

    // ---------------- assertions ----------------
    // R1
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_start && cmd_len == '0) |=> (done_o && !mem_rd_en && !mem_wr_en));

    // R2
    head_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && state_q == ST_HEAD) |-> (dst_q[AL-1:0] != '0));

    // R3
    body_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && state_q == ST_BODY) |-> ((&mem_wr_be) && dst_q[LB-1:0] == '0));

    // R4
    tail_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && state_q == ST_TAIL) |-> (prog_len < LW'(WB) && mem_wr_be[0] && !mem_wr_be[WB-1]));

    // R4
    tail_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && state_q == ST_TAIL) |=> (prog_len == '0));

    // R5
    done_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> ($past(state_q) == ST_TAIL || $past(state_q) == ST_IDLE));

    // R8
    progress_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> ((prog_dst - $past(prog_dst)) == AW'($past(prog_len) - prog_len)
                       && (prog_src - $past(prog_src)) == (prog_dst - $past(prog_dst))));

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && in_phase) |=> (!busy_o && prog_len == $past(prog_len) && prog_dst == $past(prog_dst)));

    // R11
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && in_phase) |-> (!mem_rd_en && !mem_wr_en));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && in_phase) |=> $stable(prog_len));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/memcpy3_engine_tb.sv
module memcpy3_engine_tb;
    localparam int AW = 8;
    localparam int LW = 8;
    localparam int WB = 4;
    localparam int AB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cmd_start = 1'b0;
    logic [7:0]    cmd_src = '0, cmd_dst = '0, cmd_len = '0;
    logic [1:0]    cmd_phase = '0;
    logic          abort_i = 1'b0, stall_i = 1'b0;
    logic          mem_rd_en, mem_wr_en;
    logic [5:0]    mem_rd_addr, mem_wr_addr;
    logic [31:0]   mem_rd_data, mem_wr_data;
    logic [3:0]    mem_wr_be;
    logic [7:0]    prog_src, prog_dst, prog_len;
    logic [1:0]    prog_phase;
    logic          busy_o, done_o;

    memcpy3_engine #(.AW(AW), .LW(LW), .WB(WB), .AB(AB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
        .cmd_len(cmd_len), .cmd_phase(cmd_phase),
        .abort_i(abort_i), .stall_i(stall_i),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
        .prog_src(prog_src), .prog_dst(prog_dst), .prog_len(prog_len),
        .prog_phase(prog_phase), .busy_o(busy_o), .done_o(done_o)
    );

    // ---------------- memory model and monitors ----------------
    logic [7:0] mem [256];
    int wcount [64];
    int acc, body_idle, head_wr, tail_wr, stall_viol, seed;
    logic [3:0] seen;
    logic [1:0] last_ph;
    bit mono_bad;

    always_comb begin
        for (int b = 0; b < 4; b++)
            mem_rd_data[8*b +: 8] = mem[{mem_rd_addr, 2'(b)}];
    end

    always @(posedge clk) begin
        if (mem_rd_en || mem_wr_en) acc = acc + 1;
        if (stall_i && (mem_rd_en || mem_wr_en)) stall_viol = stall_viol + 1;
        if (mem_wr_en) begin
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) mem[{mem_wr_addr, 2'(b)}] = mem_wr_data[8*b +: 8];
            wcount[mem_wr_addr] = wcount[mem_wr_addr] + 1;
            if (prog_phase == 2'd0) head_wr = head_wr + 1;
            if (prog_phase == 2'd2) tail_wr = tail_wr + 1;
        end
        if (busy_o && !done_o) begin
            if (prog_phase < last_ph) mono_bad = 1'b1;
            last_ph = prog_phase;
            seen[prog_phase] = 1'b1;
            if (prog_phase == 2'd1 && !mem_wr_en) body_idle = body_idle + 1;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ib(input int i);
        return 8'((i & 255) * 29 + seed * 13 + 7);
    endfunction

    task automatic init_mem(input int s);
        seed = s;
        for (int i = 0; i < 256; i++) mem[i] = ib(i);
        for (int w = 0; w < 64; w++) wcount[w] = 0;
        acc = 0; body_idle = 0; head_wr = 0; tail_wr = 0; stall_viol = 0;
        seen = '0; last_ph = '0; mono_bad = 1'b0;
    endtask

    function automatic int mem_bad(input int src, input int dst, input int copied);
        int bad = 0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] e;
            e = (i >= dst && i < dst + copied) ? ib(src + i - dst) : ib(i);
            if (mem[i] !== e) bad++;
        end
        return bad;
    endfunction

    function automatic int words_bad(input int dst, input int len);
        int bad = 0;
        for (int w = 0; w < 64; w++) begin
            int e;
            e = (len != 0 && w * 4 + 3 >= dst && w * 4 < dst + len) ? 1 : 0;
            if (wcount[w] != e) bad++;
        end
        return bad;
    endfunction

    task automatic do_cmd(input int src, input int dst, input int len, input int ph);
        cmd_src = 8'(src); cmd_dst = 8'(dst); cmd_len = 8'(len); cmd_phase = 2'(ph);
        last_ph = 2'(ph);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done(input int abort_after, input bit stall_on,
                             output bit got, output int cyc);
        got = 1'b0; cyc = 0;
        forever begin
            if (done_o) begin
                got = 1'b1;
                @(negedge clk);
                // R12: single-cycle pulse, then idle
                chk(!done_o && !busy_o, "R12", int'(done_o), 0);
                break;
            end
            if (!busy_o) break;
            if (cyc == abort_after) begin
                stall_i = 1'b0;
                abort_i = 1'b1;
                @(negedge clk);
                abort_i = 1'b0;
                break;
            end
            stall_i = stall_on && ((cyc % 3) == 1);
            @(negedge clk);
            cyc++;
            if (cyc > 400) break;
        end
        stall_i = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        bit got;
        int cyc;
        init_mem(1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!busy_o && !done_o && !mem_rd_en && !mem_wr_en && prog_len == 0,
            "R12", int'(busy_o), 0);

        // exhaustive sweep of offsets and lengths
        for (int so = 0; so < 8; so++) begin
            for (int dso = 0; dso < 8; dso++) begin
                for (int len = 0; len < 20; len++) begin
                    int src, dst, h, t, hw;
                    src = 8 + so;
                    dst = 128 + dso;
                    init_mem(so * 160 + dso * 20 + len);
                    do_cmd(src, dst, len, 0);
                    wait_done(-1, 1'b0, got, cyc);
                    if (len == 0) begin
                        // R1: done right after the command edge, no access
                        chk(got && cyc == 0 && acc == 0, "R1", acc, 0);
                    end else begin
                        h  = (8 - (dst & 7)) & 7;
                        if (h > len) h = len;
                        t  = (len - h) & 3;
                        hw = (h == 0) ? 0 : (((dst + h - 1) >> 2) - (dst >> 2) + 1);
                        chk(got, "R12", int'(got), 1);
                        // R6: byte-exact copy, neighbours untouched
                        chk(mem_bad(src, dst, len) == 0, "R6", mem_bad(src, dst, len), 0);
                        // R8: progress registers at completion
                        chk(prog_len == 0 && prog_dst == 8'(dst + len) && prog_src == 8'(src + len),
                            "R8", int'(prog_dst), dst + len);
                        // R7: each destination word written once
                        chk(words_bad(dst, len) == 0, "R7", words_bad(dst, len), 0);
                        // R5: phase order 0,1,2
                        chk(seen[2:0] == 3'b111 && !mono_bad, "R5", int'(seen), 7);
                        // R3: body phase keeps one write per cycle
                        chk(body_idle <= 2, "R3", body_idle, 2);
                        // R2: head write count
                        chk(head_wr == hw, "R2", head_wr, hw);
                        // R4: tail write count
                        chk(tail_wr == ((t != 0) ? 1 : 0), "R4", tail_wr, (t != 0) ? 1 : 0);
                    end
                end
            end
        end

        // abort at each cycle position, then resume
        for (int ab = 0; ab < 18; ab++) begin
            int copied;
            init_mem(500 + ab);
            do_cmd(3, 133, 29, 0);
            wait_done(ab, 1'b0, got, cyc);
            if (!got) begin
                copied = 29 - int'(prog_len);
                // R9: memory agrees with the progress registers
                chk(mem_bad(3, 133, copied) == 0, "R9", mem_bad(3, 133, copied), 0);
                chk(prog_src == 8'(3 + copied) && prog_dst == 8'(133 + copied) && !busy_o,
                    "R9", int'(prog_dst), 133 + copied);
                do_cmd(int'(prog_src), int'(prog_dst), int'(prog_len), int'(prog_phase));
                wait_done(-1, 1'b0, got, cyc);
            end
            // R10: resumed copy is complete
            chk(got && mem_bad(3, 133, 29) == 0, "R10", mem_bad(3, 133, 29), 0);
        end

        // stall patterns
        for (int so = 0; so < 4; so++) begin
            for (int dso = 0; dso < 8; dso++) begin
                init_mem(900 + so * 8 + dso);
                do_cmd(16 + so, 160 + dso, 13, 0);
                wait_done(-1, 1'b1, got, cyc);
                // R11: stalled cycles are silent and harmless
                chk(got && stall_viol == 0, "R11", stall_viol, 0);
                chk(mem_bad(16 + so, 160 + dso, 13) == 0, "R11",
                    mem_bad(16 + so, 160 + dso, 13), 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule